// File: doc/BRIEF.md
# SPI flash identify and unlock sequencer

This block runs once after reset, when the system has already fetched the three identification bytes from a serial NOR flash. On a start pulse it looks up the device code, which is the last of the three bytes, in a built-in table of known parts. From the lookup it reports the geometry and the write method that a later programming engine needs: capacity, sector size, page-program or word auto-increment mode, page size, program opcode and erase opcode. An unknown code raises an unsupported flag. In that case the block sends nothing on the flash bus.

For a known part the block then removes the power-up write protection. It sends a one-byte frame that arms the status register for writing. It then sends a two-byte frame that writes zero into that register. Last, it reads the register back and exposes the value. The block drives a byte-level SPI master. For each byte it raises a request with the byte and an end-of-frame marker. It holds the request until the master reports the byte done, together with the byte received and an error indication. An error on any byte of the unlock frames sets a warning flag. The readback still takes place.

Top module: `flash_ident_unlock`

## Requirements
- R1: After reset, busy, done, unsupported, warn and spi_req are 0, status_out is 0, and capacity, sector_bytes, page_bytes, prog_opcode and erase_opcode are all 0.
- R2: Only id_resp[7:0] selects the device. id_resp[7:0] is the third identification byte. id_resp[23:8] has no effect on any result.
- R3: For a known code, sector_bytes is 4096 and capacity is 4096 times the sector count of that code. The sector counts are: 0x01→16, 0x02→32, 0x03→64, 0x04→128, 0x05→256, 0x14→256, 0x41→512, 0x4A→1024, 0x4B→2048, 0x80→256, 0x8D→128 and 0x8E→256.
- R4: Code 0x4B selects page mode, with page_mode=1, page_bytes=256 and prog_opcode=0x02. Every other known code gives page_mode=0, page_bytes=0 and prog_opcode=0xAD.
- R5: For a known code erase_opcode is 0x20. After an unknown code it is 0x00.
- R6: An unknown code sets unsupported=1 and zeroes all geometry outputs. No spi_req is issued during that run.
- R7: For a known code, the bytes issued are, as (byte, spi_last) pairs: (0x50,1), (0x01,0), (0x00,1), (0x05,0), (0x00,1), in that order.
- R8: While spi_req is high and spi_done is low, spi_req stays high in the next cycle and spi_tx and spi_last keep their values.
- R9: status_out takes the spi_rx value returned with the fifth byte, which is the readback data byte.
- R10: spi_fail on any of the first three bytes sets warn=1, and the readback still runs. spi_fail on the two readback bytes does not set warn. warn is cleared at each accepted start.
- R11: A start pulse while busy=1 has no effect on the running sequence or on its results.
- R12: busy is high from the cycle after an accepted start until the run ends. done is a one-cycle pulse in the first cycle in which busy is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the block is idle |
| id_resp | input | 24 | Identification bytes; [7:0] is the third byte |
| spi_req | output | 1 | Byte transfer request to the SPI master |
| spi_tx | output | 8 | Byte to transmit |
| spi_last | output | 1 | Chip select is released after this byte |
| spi_done | input | 1 | Master has finished the requested byte |
| spi_rx | input | 8 | Byte received during the finished transfer |
| spi_fail | input | 1 | The finished transfer failed |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| unsupported | output | 1 | The last lookup found no matching code |
| warn | output | 1 | An unlock byte failed during the last run |
| status_out | output | 8 | Status register value read back |
| capacity | output | 24 | Device size in bytes |
| sector_bytes | output | 13 | Erase sector size in bytes |
| page_mode | output | 1 | 1: page program, 0: word auto-increment |
| page_bytes | output | 9 | Program page size in bytes, 0 in word mode |
| prog_opcode | output | 8 | Program opcode for the detected mode |
| erase_opcode | output | 8 | Sector erase opcode |

## Verification
The assertions assume that the SPI master answers each request with a single-cycle spi_done pulse. They also assume that spi_done is never raised without a pending request, and that spi_fail and spi_rx are meaningful only in the cycle in which spi_done is high. The bench's master model raises spi_done for exactly one cycle after it sees a request, and it drops spi_done before it can accept another byte. Each accepted byte therefore takes two cycles. The bench changes start and id_resp only on falling edges, so the register that loads the code always sees a stable value.

// File: rtl/fid_pkg.sv
package fid_pkg;

  localparam int CODE_W     = 8;
  localparam int CNT_W      = 12;
  localparam int SECT_SHIFT = 12;

  localparam logic [7:0] OP_ARM_SR   = 8'h50;
  localparam logic [7:0] OP_SR_WRITE = 8'h01;
  localparam logic [7:0] OP_SR_READ  = 8'h05;
  localparam logic [7:0] OP_ERASE_4K = 8'h20;
  localparam logic [7:0] OP_PAGE_PRG = 8'h02;
  localparam logic [7:0] OP_WORD_PRG = 8'hAD;

  typedef struct packed {
    logic             hit;
    logic [CNT_W-1:0] sectors;
    logic             page_mode;
  } dev_info_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MATCH, ST_ARM, ST_WR_OP, ST_WR_DATA, ST_RD_OP, ST_RD_DATA
  } seq_st_t;

  // Device code to geometry; unknown codes miss.
  function automatic dev_info_t fid_lookup(input logic [CODE_W-1:0] code);
    dev_info_t r;
    r = '0;
    r.hit = 1'b1;
    case (code)
      8'h01: r.sectors = 12'd16;
      8'h02: r.sectors = 12'd32;
      8'h03: r.sectors = 12'd64;
      8'h04: r.sectors = 12'd128;
      8'h8D: r.sectors = 12'd128;
      8'h05: r.sectors = 12'd256;
      8'h14: r.sectors = 12'd256;
      8'h80: r.sectors = 12'd256;
      8'h8E: r.sectors = 12'd256;
      8'h41: r.sectors = 12'd512;
      8'h4A: r.sectors = 12'd1024;
      8'h4B: begin r.sectors = 12'd2048; r.page_mode = 1'b1; end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [CNT_W+SECT_SHIFT-1:0] fid_capacity(input logic [CNT_W-1:0] n);
    return {n, {SECT_SHIFT{1'b0}}};
  endfunction

  // Byte and end-of-frame marker issued in each transfer state.
  function automatic logic [8:0] fid_state_byte(input seq_st_t st);
    case (st)
      ST_ARM:     return {OP_ARM_SR,   1'b1};
      ST_WR_OP:   return {OP_SR_WRITE, 1'b0};
      ST_WR_DATA: return {8'h00,       1'b1};
      ST_RD_OP:   return {OP_SR_READ,  1'b0};
      ST_RD_DATA: return {8'h00,       1'b1};
      default:    return 9'h000;
    endcase
  endfunction

endpackage

// File: rtl/fid_match.sv
module fid_match
  import fid_pkg::*;
#(
  parameter int CODE_W_P = CODE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CODE_W_P-1:0] code,
  output dev_info_t           info,
  output logic                known
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      info  <= '0;
      known <= 1'b0;
    end else if (load) begin
      info  <= fid_lookup(code);
      known <= 1'b1;
    end
  end

endmodule

// File: rtl/fid_seq.sv
module fid_seq
  import fid_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       hit,
  input  logic       spi_done,
  input  logic       spi_fail,
  input  logic [7:0] spi_rx,
  output logic       spi_req,
  output logic [7:0] spi_tx,
  output logic       spi_last,
  output logic       busy,
  output logic       done,
  output logic       warn,
  output logic [7:0] status,
  output logic       load,
  output logic       xfer_fire
);

  seq_st_t st;
  logic    in_unlock;

  assign busy      = (st != ST_IDLE);
  assign spi_req   = busy && (st != ST_MATCH);
  assign {spi_tx, spi_last} = fid_state_byte(st);
  assign load      = (st == ST_IDLE) && start;
  assign xfer_fire = spi_req && spi_done;
  assign in_unlock = (st == ST_ARM) || (st == ST_WR_OP) || (st == ST_WR_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      done   <= 1'b0;
      warn   <= 1'b0;
      status <= 8'h00;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_MATCH;
          warn   <= 1'b0;
          status <= 8'h00;
        end
        ST_MATCH: if (hit) st <= ST_ARM;
                  else begin st <= ST_IDLE; done <= 1'b1; end
        default: if (xfer_fire) begin
          if (spi_fail && in_unlock) warn <= 1'b1;
          case (st)
            ST_ARM:     st <= ST_WR_OP;
            ST_WR_OP:   st <= ST_WR_DATA;
            ST_WR_DATA: st <= ST_RD_OP;
            ST_RD_OP:   st <= ST_RD_DATA;
            default: begin
              status <= spi_rx;
              st     <= ST_IDLE;
              done   <= 1'b1;
            end
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_ident_unlock.sv
module flash_ident_unlock
  import fid_pkg::*;
#(
  parameter int CAP_W  = CNT_W + SECT_SHIFT,
  parameter int SECT_W = SECT_SHIFT + 1,
  parameter int PAGE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [23:0]       id_resp,
  output logic              spi_req,
  output logic [7:0]        spi_tx,
  output logic              spi_last,
  input  logic              spi_done,
  input  logic [7:0]        spi_rx,
  input  logic              spi_fail,
  output logic              busy,
  output logic              done,
  output logic              unsupported,
  output logic              warn,
  output logic [7:0]        status_out,
  output logic [CAP_W-1:0]  capacity,
  output logic [SECT_W-1:0] sector_bytes,
  output logic              page_mode,
  output logic [PAGE_W-1:0] page_bytes,
  output logic [7:0]        prog_opcode,
  output logic [7:0]        erase_opcode
);

  localparam logic [SECT_W-1:0] SECT_SIZE = SECT_W'(1) << SECT_SHIFT;
  localparam logic [PAGE_W-1:0] PAGE_SIZE = PAGE_W'(256);

  dev_info_t info;
  logic      known;
  logic      load;
  logic      xfer_fire;
  logic      hit;

  fid_match u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .code  (id_resp[7:0]),
    .info  (info),
    .known (known)
  );

  assign hit = info.hit;

  fid_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .hit       (hit),
    .spi_done  (spi_done),
    .spi_fail  (spi_fail),
    .spi_rx    (spi_rx),
    .spi_req   (spi_req),
    .spi_tx    (spi_tx),
    .spi_last  (spi_last),
    .busy      (busy),
    .done      (done),
    .warn      (warn),
    .status    (status_out),
    .load      (load),
    .xfer_fire (xfer_fire)
  );

  assign unsupported  = known && !hit;
  assign capacity     = hit ? CAP_W'(fid_capacity(info.sectors)) : '0;
  assign sector_bytes = hit ? SECT_SIZE : '0;
  assign page_mode    = hit && info.page_mode;
  assign page_bytes   = page_mode ? PAGE_SIZE : '0;
  assign prog_opcode  = !hit ? 8'h00 : (info.page_mode ? OP_PAGE_PRG : OP_WORD_PRG);
  assign erase_opcode = hit ? OP_ERASE_4K : 8'h00;

endmodule

// File: rtl/fid_checker.sv
module fid_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_req,
  input logic [7:0] spi_tx,
  input logic       spi_last,
  input logic       spi_done,
  input logic       busy,
  input logic       done,
  input logic       unsupported,
  input logic       warn,
  input logic       xfer_fire
);

  // R8: a pending byte is held with its data until accepted
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && !spi_done) |=> (spi_req && $stable(spi_tx) && $stable(spi_last)));

  // R6: an unknown code never reaches the bus
  a_r6_no_bus_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> !spi_req);

  // R12: done is a single-cycle pulse with busy low
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));

  // R12: an idle block issues nothing
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_req);

  // R10: warn only rises as a transfer completes
  a_r10_warn_on_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn) |-> $past(xfer_fire));

endmodule

bind flash_ident_unlock fid_checker u_fid_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_req     (spi_req),
  .spi_tx      (spi_tx),
  .spi_last    (spi_last),
  .spi_done    (spi_done),
  .busy        (busy),
  .done        (done),
  .unsupported (unsupported),
  .warn        (warn),
  .xfer_fire   (xfer_fire)
);

// File: tb/tb_flash_ident_unlock.sv
`timescale 1ns/1ps
module tb_flash_ident_unlock;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] id_resp = '0;
  logic        spi_req, spi_last, spi_done = 1'b0, spi_fail = 1'b0;
  logic [7:0]  spi_tx, spi_rx = 8'h00;
  logic        busy, done, unsupported, warn, page_mode;
  logic [7:0]  status_out, prog_opcode, erase_opcode;
  logic [23:0] capacity;
  logic [12:0] sector_bytes;
  logic [8:0]  page_bytes;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  logic [7:0] lg_tx [8];
  logic       lg_end [8];
  int         lg_n = 0;
  int         fail_idx = -1;
  logic [7:0] rd_val = 8'h00;

  always #5 clk = ~clk;

  flash_ident_unlock dut (.*);

  // code[21:14], sectors[13:2], page[1], known[0]
  localparam logic [21:0] VEC [13] = '{
    {8'h4B, 12'd2048, 1'b1, 1'b1}, {8'h8D, 12'd128, 1'b0, 1'b1},
    {8'h01, 12'd16, 1'b0, 1'b1},   {8'h4A, 12'd1024, 1'b0, 1'b1},
    {8'h8E, 12'd256, 1'b0, 1'b1},  {8'h41, 12'd512, 1'b0, 1'b1},
    {8'h77, 12'd0, 1'b0, 1'b0},    {8'h02, 12'd32, 1'b0, 1'b1},
    {8'h03, 12'd64, 1'b0, 1'b1},   {8'h04, 12'd128, 1'b0, 1'b1},
    {8'h05, 12'd256, 1'b0, 1'b1},  {8'h14, 12'd256, 1'b0, 1'b1},
    {8'h80, 12'd256, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // SPI master model: one-cycle done per request
  initial forever begin
    @(negedge clk);
    if (spi_done) begin
      spi_done = 1'b0;
      spi_fail = 1'b0;
    end else if (spi_req) begin
      if (lg_n < 8) begin lg_tx[lg_n] = spi_tx; lg_end[lg_n] = spi_last; end
      spi_fail = (lg_n == fail_idx);
      spi_rx   = rd_val;
      spi_done = 1'b1;
      lg_n++;
    end
  end

  task automatic kick(input logic [23:0] id);
    @(negedge clk);
    id_resp = id;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    check(req, {31'd0, done}, 32'd1);
    @(negedge clk);
    check("R12 done single", {31'd0, done}, 32'd0);
  endtask

  task automatic run(input logic [23:0] id, input logic [7:0] rv, input int fi);
    lg_n = 0; rd_val = rv; fail_idx = fi;
    kick(id);
    check("R12 busy after start", {31'd0, busy}, 32'd1);
    wait_done("R12 done seen");
  endtask

  task automatic check_seq();
    logic [7:0] eb [5] = '{8'h50, 8'h01, 8'h00, 8'h05, 8'h00};
    logic       ee [5] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    check("R7 byte count", lg_n, 5);
    for (int k = 0; k < 5; k++) begin
      check("R7 byte", {24'd0, lg_tx[k]}, {24'd0, eb[k]});
      check("R7 frame end", {31'd0, lg_end[k]}, {31'd0, ee[k]});
    end
  endtask

  initial begin
    while (!finished && cycles < 100000) begin @(posedge clk); cycles++; end
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 done", {31'd0, done}, 0);
    check("R1 unsupported", {31'd0, unsupported}, 0);
    check("R1 req", {31'd0, spi_req}, 0);
    check("R1 geometry", {8'd0, capacity}, 0);
    check("R1 opcodes", {16'd0, prog_opcode, erase_opcode}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 13; i++) begin
      logic [7:0]  code = VEC[i][21:14];
      logic [11:0] secs = VEC[i][13:2];
      logic        pg   = VEC[i][1];
      logic        kn   = VEC[i][0];
      logic [7:0]  rv   = 8'h1C ^ 8'(i);
      // R2: upper bytes vary per vector
      run({8'(i * 37 + 3), 8'(8'hBF ^ 8'(i)), code}, rv, -1);
      check("R6 unsupported", {31'd0, unsupported}, {31'd0, !kn});
      check("R3 capacity", {8'd0, capacity}, 32'(secs) * 32'd4096);
      check("R3 sector size", {19'd0, sector_bytes}, kn ? 32'd4096 : 32'd0);
      check("R4 page mode", {31'd0, page_mode}, {31'd0, pg});
      check("R4 page size", {23'd0, page_bytes}, pg ? 32'd256 : 32'd0);
      check("R4 prog opcode", {24'd0, prog_opcode}, !kn ? 32'h00 : (pg ? 32'h02 : 32'hAD));
      check("R5 erase opcode", {24'd0, erase_opcode}, kn ? 32'h20 : 32'h00);
      check("R10 warn clear", {31'd0, warn}, 0);
      if (kn) begin
        check_seq();
        check("R9 status", {24'd0, status_out}, {24'd0, rv});
      end else begin
        check("R6 no bus activity", lg_n, 0);
      end
    end

    // R2: same code with other upper bytes gives the same result
    run(24'hFFFF4A, 8'h00, -1);
    check("R2 upper bytes ignored", {8'd0, capacity}, 32'd1024 * 32'd4096);
    run(24'h4B4B01, 8'h00, -1);
    check("R2 only byte index 2", {8'd0, capacity}, 32'd65536);

    // R10: failure on status write data byte
    run(24'h00008E, 8'h40, 2);
    check("R10 warn on unlock fail", {31'd0, warn}, 1);
    check("R10 readback still runs", lg_n, 5);
    check("R10 status after fail", {24'd0, status_out}, 32'h40);
    // R10: failure on readback byte does not warn; next start clears warn
    run(24'h00008E, 8'h02, 4);
    check("R10 no warn on readback fail", {31'd0, warn}, 0);

    // R11: start while busy is ignored
    lg_n = 0; rd_val = 8'h80; fail_idx = -1;
    kick(24'h00004B);
    repeat (3) @(negedge clk);
    id_resp = 24'h000001; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done("R11 run completes");
    check("R11 result unchanged", {8'd0, capacity}, 32'd2048 * 32'd4096);
    check("R11 single sequence", lg_n, 5);
    repeat (4) @(negedge clk);
    check("R11 no restart", {31'd0, busy}, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule